// File: doc/BRIEF.md
# Host Interrupt Aggregator

This block collects interrupt sources for the host side of a bus controller and turns them into two outputs. The first is `irq_req`, the request that software sees. It comes from a sticky event status register, a per-bit enable register and a master enable bit. The second is `int_pin`, a processor interrupt pin. It is driven by a separate sticky processor-event register, its own enable register and a global pin-enable bit. Both the level and the polarity of the pin can be configured.

Software reaches the block through a single-cycle register port. A write takes effect on the rising clock edge where `wr_en` is high. A read is combinational from `addr`. The port uses four write styles:

- The event status register and the processor status register are write-one-to-clear.
- The enable register has a set-only address and a clear-only address.
- The command register is write-one-to-set, and hardware clears its bits through `cmd_done`.
- The processor enable register and the configuration register are plain read/write registers.

Register addresses: 0 event status, 1 enable-set, 2 enable-clear, 3 command, 4 processor status, 5 processor enable, 6 configuration. Any other address reads as zero. The enable register is `EV_W+1` bits wide. Bits `EV_W-1:0` are the per-event enables and bit `EV_W` is the master enable. In the configuration register, bit 0 is the pin enable and bit 1 is the polarity (1 = active high, 0 = active low).

Top module: `intr_host_agg`

## Requirements
- R1: A high bit on `evt` sets the matching event status bit on the next edge, and the bit stays set until software clears it.
- R2: A write to address 0 clears every status bit whose `wdata` bit is 1. Status bits written with 0 keep their value.
- R3: A write to address 1 sets every enable bit (per-event enables and the master at bit `EV_W`) whose `wdata` bit is 1. The other enable bits are unchanged.
- R4: A write to address 2 clears every enable bit whose `wdata` bit is 1. The other enable bits are unchanged.
- R5: A read of address 1 and a read of address 2 both return the current enable register, zero-extended.
- R6: `irq_req` is high exactly when some status bit and its enable bit are both set and the master enable (bit `EV_W`) is set.
- R7: When an event sets a status bit in the same cycle that software writes 1 to clear it, the bit ends up set.
- R8: A write to address 3 sets every command bit written 1 and keeps the bits written 0. A high `cmd_done` bit clears its command bit. If a software set and a `cmd_done` clear hit the same bit in the same cycle, the set wins.
- R9: The processor status register (address 4) is set by `proc_evt` and is write-one-to-clear. Setting by `proc_evt` wins over a software clear in the same cycle. The pin is asserted only when some processor status bit and its enable bit at address 5 are both set and configuration bit 0 is 1.
- R10: Configuration bit 1 selects the active level of `int_pin`: 1 means asserted high, 0 means asserted low. When the pin is not asserted it sits at the opposite level.
- R11: After reset every register reads 0, `irq_req` is low, `cmd_bits` is 0, and `int_pin` is 1 (inactive, active-low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | EV_W | Hardware event pulses for the event status register |
| proc_evt | input | PI_W | Hardware event pulses for the processor status register |
| cmd_done | input | CMD_W | Hardware clear for command bits |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| cmd_bits | output | CMD_W | Current command register |
| irq_req | output | 1 | Aggregated interrupt request |
| int_pin | output | 1 | Processor interrupt pin |

## Verification
The hardest case to reach is a hardware set and a software clear landing on the same bit in the same cycle. This applies to the status register, the command register and the processor status register. The bench lines up an event pulse and a write on one falling edge, so both act on the same rising edge. It does the same for an event on one bit while a different bit is cleared, which shows that the two paths are separated per bit. The pin is swept over every combination of pin enable, polarity and processor enable while the processor status bit is held set.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_STAT   = 3'd0,
      A_EN_SET = 3'd1,
      A_EN_CLR = 3'd2,
      A_CMD    = 3'd3,
      A_PSTAT  = 3'd4,
      A_PEN    = 3'd5,
      A_HWCFG  = 3'd6
   } reg_sel_e;

   localparam int HW_PIN_EN_BIT = 0;
   localparam int HW_POL_BIT    = 1;
   localparam int HWCFG_W       = 2;
endpackage

// File: rtl/intr_bit_bank.sv
// Sticky bit vector: each bit has an independent set and clear request.
// SET_PRIORITY selects which request wins when both hit the same bit.
module intr_bit_bank #(
   parameter int W            = 8,
   parameter bit SET_PRIORITY = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_v,
   input  logic [W-1:0] clr_v,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("intr_bit_bank: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic nxt;
      if (SET_PRIORITY) begin : g_setwin
         assign nxt = set_v[i] | (q[i] & ~clr_v[i]);
      end else begin : g_clrwin
         assign nxt = (q[i] | set_v[i]) & ~clr_v[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[i] <= 1'b0;
         else        q[i] <= nxt;
      end
   end
endmodule

// File: rtl/intr_plain_reg.sv
// Plain write-enabled register with a zero reset value.
module intr_plain_reg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("intr_plain_reg: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end
endmodule

// File: rtl/intr_pin_drv.sv
// Gates the processor interrupt vector onto the pin and applies the polarity.
module intr_pin_drv #(
   parameter int PW      = 4,
   parameter bit PIN_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] pend,
   input  logic [PW-1:0] pmask,
   input  logic          pin_en,
   input  logic          act_high,
   output logic          pin
);
   logic asserted;
   logic level;

   assign asserted = pin_en & (|(pend & pmask));
   assign level    = act_high ? asserted : ~asserted;

   if (PIN_REG) begin : g_reg
      logic pin_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pin_q <= 1'b1;
         else        pin_q <= level;
      end
      assign pin = pin_q;
   end else begin : g_comb
      assign pin = level;
   end
endmodule

// File: rtl/intr_host_agg.sv
module intr_host_agg
   import intr_agg_pkg::*;
#(
   parameter int EV_W    = 8,
   parameter int PI_W    = 4,
   parameter int CMD_W   = 4,
   parameter int DATA_W  = 16,
   parameter bit PIN_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EV_W-1:0]   evt,
   input  logic [PI_W-1:0]   proc_evt,
   input  logic [CMD_W-1:0]  cmd_done,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [CMD_W-1:0]  cmd_bits,
   output logic              irq_req,
   output logic              int_pin
);
   localparam int EN_W   = EV_W + 1;
   localparam int MASTER = EV_W;

   if (DATA_W < EN_W)    begin : g_bad_en  $error("DATA_W too narrow for enables"); end
   if (DATA_W < PI_W)    begin : g_bad_pi  $error("DATA_W too narrow for PI_W"); end
   if (DATA_W < CMD_W)   begin : g_bad_cmd $error("DATA_W too narrow for CMD_W"); end
   if (DATA_W < HWCFG_W) begin : g_bad_hw  $error("DATA_W too narrow for config"); end

   logic wr_stat, wr_eset, wr_eclr, wr_cmd, wr_pstat, wr_pen, wr_hw;
   assign wr_stat  = wr_en && (addr == A_STAT);
   assign wr_eset  = wr_en && (addr == A_EN_SET);
   assign wr_eclr  = wr_en && (addr == A_EN_CLR);
   assign wr_cmd   = wr_en && (addr == A_CMD);
   assign wr_pstat = wr_en && (addr == A_PSTAT);
   assign wr_pen   = wr_en && (addr == A_PEN);
   assign wr_hw    = wr_en && (addr == A_HWCFG);

   logic [EV_W-1:0]    status_q;
   logic [EN_W-1:0]    enable_q;
   logic [CMD_W-1:0]   cmd_q;
   logic [PI_W-1:0]    pstat_q;
   logic [PI_W-1:0]    pen_q;
   logic [HWCFG_W-1:0] hwcfg_q;

   // event status: hardware sets, software writes 1 to clear, set wins
   intr_bit_bank #(.W(EV_W), .SET_PRIORITY(1'b1)) u_status (
      .clk(clk), .rst_n(rst_n),
      .set_v(evt),
      .clr_v(wr_stat ? wdata[EV_W-1:0] : '0),
      .q(status_q)
   );

   // enables: separate set-only and clear-only addresses
   intr_bit_bank #(.W(EN_W), .SET_PRIORITY(1'b1)) u_enable (
      .clk(clk), .rst_n(rst_n),
      .set_v(wr_eset ? wdata[EN_W-1:0] : '0),
      .clr_v(wr_eclr ? wdata[EN_W-1:0] : '0),
      .q(enable_q)
   );

   // command: software writes 1 to set, hardware completion clears
   intr_bit_bank #(.W(CMD_W), .SET_PRIORITY(1'b1)) u_cmd (
      .clk(clk), .rst_n(rst_n),
      .set_v(wr_cmd ? wdata[CMD_W-1:0] : '0),
      .clr_v(cmd_done),
      .q(cmd_q)
   );

   // processor status: hardware sets, software writes 1 to clear
   intr_bit_bank #(.W(PI_W), .SET_PRIORITY(1'b1)) u_pstat (
      .clk(clk), .rst_n(rst_n),
      .set_v(proc_evt),
      .clr_v(wr_pstat ? wdata[PI_W-1:0] : '0),
      .q(pstat_q)
   );

   intr_plain_reg #(.W(PI_W)) u_pen (
      .clk(clk), .rst_n(rst_n), .we(wr_pen),
      .d(wdata[PI_W-1:0]), .q(pen_q)
   );

   intr_plain_reg #(.W(HWCFG_W)) u_hwcfg (
      .clk(clk), .rst_n(rst_n), .we(wr_hw),
      .d(wdata[HWCFG_W-1:0]), .q(hwcfg_q)
   );

   intr_pin_drv #(.PW(PI_W), .PIN_REG(PIN_REG)) u_pin (
      .clk(clk), .rst_n(rst_n),
      .pend(pstat_q), .pmask(pen_q),
      .pin_en(hwcfg_q[HW_PIN_EN_BIT]),
      .act_high(hwcfg_q[HW_POL_BIT]),
      .pin(int_pin)
   );

   assign irq_req  = enable_q[MASTER] & (|(status_q & enable_q[EV_W-1:0]));
   assign cmd_bits = cmd_q;

   always_comb begin
      rdata = '0;
      case (addr)
         A_STAT:            rdata = DATA_W'(status_q);
         A_EN_SET, A_EN_CLR: rdata = DATA_W'(enable_q);
         A_CMD:             rdata = DATA_W'(cmd_q);
         A_PSTAT:           rdata = DATA_W'(pstat_q);
         A_PEN:             rdata = DATA_W'(pen_q);
         A_HWCFG:           rdata = DATA_W'(hwcfg_q);
         default:           rdata = '0;
      endcase
   end
endmodule

// File: rtl/intr_host_agg_chk.sv
module intr_host_agg_chk
   import intr_agg_pkg::*;
#(
   parameter int EV_W    = 8,
   parameter int CMD_W   = 4,
   parameter int DATA_W  = 16,
   parameter bit PIN_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [EV_W-1:0]   evt,
   input logic [EV_W-1:0]   status_q,
   input logic [EV_W:0]     enable_q,
   input logic [CMD_W-1:0]  cmd_q,
   input logic [1:0]        hwcfg_q,
   input logic              irq_req,
   input logic              int_pin
);
   // R1
   evt_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((status_q & $past(evt)) == $past(evt)));

   // R2
   stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_STAT) |=>
      ((status_q & $past(wdata[EV_W-1:0] & ~evt)) == '0));

   // R3
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_EN_SET) |=>
      ((enable_q & $past(wdata[EV_W:0])) == $past(wdata[EV_W:0])));

   // R4
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_EN_CLR) |=> ((enable_q & $past(wdata[EV_W:0])) == '0));

   // R6
   no_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_q[EV_W] |-> !irq_req);

   // R8
   cmd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CMD) |=>
      ((cmd_q & $past(wdata[CMD_W-1:0])) == $past(wdata[CMD_W-1:0])));

   if (!PIN_REG) begin : g_pin_chk
      // R10
      pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !hwcfg_q[HW_PIN_EN_BIT] |-> (int_pin == !hwcfg_q[HW_POL_BIT]));
   end
endmodule

bind intr_host_agg intr_host_agg_chk #(
   .EV_W(EV_W), .CMD_W(CMD_W), .DATA_W(DATA_W), .PIN_REG(PIN_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .evt(evt), .status_q(status_q), .enable_q(enable_q), .cmd_q(cmd_q),
   .hwcfg_q(hwcfg_q), .irq_req(irq_req), .int_pin(int_pin)
);

// File: tb/intr_host_agg_test.sv
module intr_host_agg_test;
   localparam int EV_W = 8, PI_W = 4, CMD_W = 4, DW = 16;
   localparam logic [2:0] AST = 0, AES = 1, AEC = 2, ACMD = 3,
                          APST = 4, APEN = 5, AHW = 6;

   logic clk = 0, rst_n = 0;
   logic [EV_W-1:0]  evt = '0;
   logic [PI_W-1:0]  proc_evt = '0;
   logic [CMD_W-1:0] cmd_done = '0;
   logic wr_en = 0;
   logic [2:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic [CMD_W-1:0] cmd_bits;
   logic irq_req, int_pin;

   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   intr_host_agg uut (
      .clk(clk), .rst_n(rst_n), .evt(evt), .proc_evt(proc_evt),
      .cmd_done(cmd_done), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .cmd_bits(cmd_bits), .irq_req(irq_req), .int_pin(int_pin)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1;
      @(negedge clk); wr_en = 0; wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic pulse_evt(input logic [EV_W-1:0] v);
      @(negedge clk); evt = v;
      @(negedge clk); evt = '0;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      logic [EV_W-1:0] est;
      logic [EV_W:0] een;
      logic [CMD_W-1:0] ecmd;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R11 reset state
      for (int a = 0; a < 8; a++) begin
         rd(a[2:0], d); chk("R11 reg reset", d, 0);
      end
      chk("R11 irq_req reset", irq_req, 0);
      chk("R11 cmd_bits reset", cmd_bits, 0);
      chk("R11 int_pin reset", int_pin, 1);

      // R1 sweep of every status bit, accumulating
      est = '0;
      for (int i = 0; i < EV_W; i++) begin
         pulse_evt(EV_W'(1) << i);
         est |= EV_W'(1) << i;
         rd(AST, d); chk("R1 status set", d, DW'(est));
      end
      // R2 write-one-to-clear and write-zero
      wr(AST, 16'h0055); est &= ~8'h55;
      rd(AST, d); chk("R2 w1c pattern", d, DW'(est));
      wr(AST, 16'h0000);
      rd(AST, d); chk("R2 zero write", d, DW'(est));
      wr(AST, 16'h00FF); est = '0;
      rd(AST, d); chk("R2 clear all", d, 0);

      // R3 R4 R5 enable set/clear sweep
      een = '0;
      for (int k = 0; k < 32; k++) begin
         logic [EV_W:0] p, q;
         p = 9'((k * 37) % 512);
         q = 9'((k * 91 + 5) % 512);
         wr(AES, DW'(p)); een |= p;
         rd(AES, d); chk("R3 set via set addr", d, DW'(een));
         rd(AEC, d); chk("R5 read clr addr", d, DW'(een));
         wr(AEC, DW'(q)); een &= ~q;
         rd(AEC, d); chk("R4 clear via clr addr", d, DW'(een));
         rd(AES, d); chk("R5 read set addr", d, DW'(een));
      end
      wr(AEC, 16'h01FF); een = '0;

      // R6 request gating
      wr(AES, 16'h00FF);
      pulse_evt(8'h04);
      @(negedge clk); chk("R6 no master", irq_req, 0);
      wr(AES, 16'h0100);
      chk("R6 master on", irq_req, 1);
      wr(AEC, 16'h0004);
      chk("R6 bit disabled", irq_req, 0);
      wr(AES, 16'h0004);
      chk("R6 bit re-enabled", irq_req, 1);
      wr(AST, 16'h0004);
      chk("R6 status cleared", irq_req, 0);

      // R7 simultaneous set and clear
      pulse_evt(8'h20);
      @(negedge clk); addr = AST; wdata = 16'h0028; wr_en = 1; evt = 8'h08;
      @(negedge clk); wr_en = 0; evt = '0; wdata = '0;
      rd(AST, d); chk("R7 set wins, other bit cleared", d, 16'h0008);
      chk("R7 irq with set bit", irq_req, 1);
      wr(AST, 16'h00FF);

      // R8 command register
      ecmd = '0;
      wr(ACMD, 16'h0005); ecmd = 4'h5; chk("R8 cmd set", cmd_bits, ecmd);
      wr(ACMD, 16'h0002); ecmd = 4'h7; chk("R8 cmd accumulate", cmd_bits, ecmd);
      wr(ACMD, 16'h0000); chk("R8 cmd zero write", cmd_bits, ecmd);
      @(negedge clk); cmd_done = 4'h1;
      @(negedge clk); cmd_done = '0; ecmd = 4'h6;
      rd(ACMD, d); chk("R8 cmd done clears", d, DW'(ecmd));
      @(negedge clk); addr = ACMD; wdata = 16'h0008; wr_en = 1; cmd_done = 4'hA;
      @(negedge clk); wr_en = 0; cmd_done = '0; ecmd = 4'hC;
      chk("R8 set beats done", cmd_bits, ecmd);

      // R9 R10 processor pin sweep
      @(negedge clk); proc_evt = 4'h2;
      @(negedge clk); proc_evt = '0;
      rd(APST, d); chk("R9 proc status set", d, 16'h0002);
      for (int hw = 0; hw < 4; hw++) begin
         for (int pe = 0; pe < 2; pe++) begin
            logic act, pol, exp_pin;
            wr(AHW, DW'(hw));
            wr(APEN, pe ? 16'h0002 : 16'h000D);
            act = (hw & 1) && pe;
            pol = (hw >> 1) & 1;
            exp_pin = pol ? act : !act;
            chk("R9 R10 pin level", int_pin, exp_pin);
         end
      end
      wr(AHW, 16'h0001); wr(APEN, 16'h0002);
      chk("R10 active low asserted", int_pin, 0);
      @(negedge clk); addr = APST; wdata = 16'h0006; wr_en = 1; proc_evt = 4'h4;
      @(negedge clk); wr_en = 0; proc_evt = '0; wdata = '0;
      rd(APST, d); chk("R9 proc w1c with set", d, 16'h0004);
      chk("R9 pin released", int_pin, 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule